// File: doc/BRIEF.md
# Vector Multiply-Add Carry Sequencer

This block runs an unsigned three-source, two-result multiply-add over a short vector of elements kept in its own register file. For every element it forms the 128-bit value A*B+C from 64-bit operands. The low 64 bits go to a low destination register. The high 64 bits go to a second destination, which a single mode input selects. In one mode the high half goes back into the C register. In the other mode it goes to the register found VL entries above the low destination.

Each of the four named operands (A, B, C and the low destination) carries its own scalar/vector flag. A scalar operand uses one register for every element. A vector operand steps by one register per element. Elements are handled in ascending order, one per clock. When C is scalar and the high half is written back to C, each element's high half therefore becomes the carry word for the next element. A run of this kind is a big-integer multiply-by-word. The other mode writes the high halves to a separate block and keeps C intact.

A start/busy/done handshake launches and finishes a run. A load port and an asynchronous read port give a test environment access to the register file.

Top module: `vmac_seq`

## Requirements
- R1: After reset, busy and done are low and every register-file entry reads zero.
- R2: For element i, the low destination register receives bits 63:0 of A_i*B_i+C_i, where the operands are read from the register file after all writes of element i-1 have been committed.
- R3: For element i, bits 127:64 of the result go to the high destination. With mode=0 that is the C register of element i. With mode=1 it is the low destination index of element i plus VL.
- R4: An operand with flag 0 (scalar) uses its base index for every element. An operand with flag 1 (vector) uses base+i. All index arithmetic wraps modulo the register count (64).
- R5: With C scalar and mode=0, the high half of element i is the C value seen by element i+1, so the run forms a multiply-by-word carry chain.
- R6: With mode=1, C registers that are not a destination keep their value through the run.
- R7: After a start is accepted with effective length N>0, busy reads high for exactly N cycles. done then pulses high for one cycle, in the first cycle with busy low, after the last element's writes have been committed.
- R8: A start with VL=0 writes nothing, never raises busy, and pulses done in the cycle that follows.
- R9: A start pulse seen while busy is ignored, and the running operation continues unchanged.
- R10: When the low and high destinations of an element are the same register, that register holds the high half.
- R11: The load port writes an entry only while the block is idle. A load request while busy has no effect.
- R12: All-ones A, B and C give high half 0xFFFF_FFFF_FFFF_FFFF and low half 0, with no lost carry.
- R13: A VL input above 16 runs as VL=16. This covers both the element count and the mode=1 offset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch request, accepted when idle |
| vl | input | 5 | Requested vector length |
| hi_mode | input | 1 | 0: high half to C; 1: high half to low destination + VL |
| a_base | input | 6 | Base index of A |
| b_base | input | 6 | Base index of B |
| c_base | input | 6 | Base index of C |
| t_base | input | 6 | Base index of the low destination |
| a_vec | input | 1 | A steps per element when 1 |
| b_vec | input | 1 | B steps per element when 1 |
| c_vec | input | 1 | C steps per element when 1 |
| t_vec | input | 1 | Low destination steps per element when 1 |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| ld_we | input | 1 | Load-port write enable |
| ld_addr | input | 6 | Load-port write index |
| ld_data | input | 64 | Load-port write data |
| rd_addr | input | 6 | Test read index |
| rd_data | output | 64 | Test read data (combinational) |

## Verification
The bench uses the default parameters: 64 registers of 64 bits and a maximum vector length of 16. The 5-bit length input therefore reaches values from 17 to 31, which exercises the clamp. With a low destination base near the top of the file, the clamped run wraps both the vector indices and the high-destination offset past entry 63. The scenarios cover carry chains, destination collisions and an all-ones operand set. After each run the bench compares the whole file against its own model.

// File: rtl/vmac_pkg.sv
package vmac_pkg;

  // Operand slot order used by the address generator
  localparam int OP_A = 0;
  localparam int OP_B = 1;
  localparam int OP_C = 2;
  localparam int OP_T = 3;
  localparam int OP_N = 4;

  typedef enum logic {
    HI_ON_C    = 1'b0,
    HI_PAST_RT = 1'b1
  } hi_dest_e;

endpackage

// File: rtl/vmac_rf.sv
module vmac_rf #(
  parameter int DW   = 64,
  parameter int NREG = 64,
  localparam int AW  = $clog2(NREG)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [3:0][AW-1:0]    rd_idx,
  output logic [3:0][DW-1:0]    rd_val,
  input  logic                  lo_we,
  input  logic [AW-1:0]         lo_idx,
  input  logic [DW-1:0]         lo_val,
  input  logic                  hi_we,
  input  logic [AW-1:0]         hi_idx,
  input  logic [DW-1:0]         hi_val,
  input  logic                  ld_we,
  input  logic [AW-1:0]         ld_idx,
  input  logic [DW-1:0]         ld_val
);

  logic [DW-1:0] mem [NREG];

  // Later assignment wins: high half over low half over load
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++) mem[r] <= '0;
    end else begin
      if (ld_we) mem[ld_idx] <= ld_val;
      if (lo_we) mem[lo_idx] <= lo_val;
      if (hi_we) mem[hi_idx] <= hi_val;
    end
  end

  for (genvar p = 0; p < 4; p++) begin : g_rd
    assign rd_val[p] = mem[rd_idx[p]];
  end

  wire same_dest = lo_we && hi_we && (lo_idx == hi_idx);

  // R10
  hi_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    same_dest |=> (mem[$past(hi_idx)] == $past(hi_val)));

  // R11
  ld_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_we |-> !(lo_we || hi_we));

endmodule

// File: rtl/vmac_agen.sv
module vmac_agen
  import vmac_pkg::*;
#(
  parameter int AW  = 6,
  parameter int VLW = 5
) (
  input  logic [OP_N-1:0][AW-1:0] base,
  input  logic [OP_N-1:0]         vec,
  input  logic [VLW-1:0]          elem,
  input  logic [VLW-1:0]          vlen,
  input  hi_dest_e                mode,
  output logic [OP_N-1:0][AW-1:0] idx,
  output logic [AW-1:0]           s_idx
);

  function automatic logic [AW-1:0] step_of(input logic v, input logic [VLW-1:0] e);
    return v ? AW'(e) : '0;
  endfunction

  for (genvar g = 0; g < OP_N; g++) begin : g_op
    assign idx[g] = base[g] + step_of(vec[g], elem);
  end

  assign s_idx = (mode == HI_PAST_RT) ? idx[OP_T] + AW'(vlen) : idx[OP_C];

endmodule

// File: rtl/vmac_alu.sv
module vmac_alu #(
  parameter int DW = 64
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [DW-1:0] c,
  output logic [DW-1:0] lo,
  output logic [DW-1:0] hi
);

  function automatic logic [2*DW-1:0] mac_full(input logic [DW-1:0] x,
                                              input logic [DW-1:0] y,
                                              input logic [DW-1:0] z);
    logic [2*DW-1:0] xw, yw, zw;
    xw = {{DW{1'b0}}, x};
    yw = {{DW{1'b0}}, y};
    zw = {{DW{1'b0}}, z};
    return xw * yw + zw;
  endfunction

  logic [2*DW-1:0] full;
  assign full = mac_full(a, b, c);
  assign lo   = full[DW-1:0];
  assign hi   = full[2*DW-1:DW];

endmodule

// File: rtl/vmac_seq.sv
module vmac_seq
  import vmac_pkg::*;
#(
  parameter int DW    = 64,
  parameter int NREG  = 64,
  parameter int VLMAX = 16,
  localparam int AW   = $clog2(NREG),
  localparam int VLW  = $clog2(VLMAX + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [VLW-1:0] vl,
  input  logic           hi_mode,
  input  logic [AW-1:0]  a_base,
  input  logic [AW-1:0]  b_base,
  input  logic [AW-1:0]  c_base,
  input  logic [AW-1:0]  t_base,
  input  logic           a_vec,
  input  logic           b_vec,
  input  logic           c_vec,
  input  logic           t_vec,
  output logic           busy,
  output logic           done,
  input  logic           ld_we,
  input  logic [AW-1:0]  ld_addr,
  input  logic [DW-1:0]  ld_data,
  input  logic [AW-1:0]  rd_addr,
  output logic [DW-1:0]  rd_data
);

  localparam logic [VLW-1:0] VL_CAP = VLW'(VLMAX);

  // Latched operation
  logic [OP_N-1:0][AW-1:0] base_q;
  logic [OP_N-1:0]         vec_q;
  hi_dest_e                mode_q;
  logic [VLW-1:0]          vl_q;
  logic [VLW-1:0]          elem_q;
  logic                    busy_q, done_q;

  // Named events
  wire            accept   = start && !busy_q;
  wire [VLW-1:0]  vl_eff   = (vl > VL_CAP) ? VL_CAP : vl;
  wire            empty_op = accept && (vl_eff == '0);
  wire            step     = busy_q;
  wire            last_el  = busy_q && (elem_q == vl_q - VLW'(1));
  wire            ld_take  = ld_we && !busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      vec_q  <= '0;
      mode_q <= HI_ON_C;
      vl_q   <= '0;
      elem_q <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else if (accept) begin
      base_q <= {t_base, c_base, b_base, a_base};
      vec_q  <= {t_vec, c_vec, b_vec, a_vec};
      mode_q <= hi_dest_e'(hi_mode);
      vl_q   <= vl_eff;
      elem_q <= '0;
      busy_q <= (vl_eff != '0);
      done_q <= (vl_eff == '0);
    end else if (step) begin
      elem_q <= elem_q + VLW'(1);
      busy_q <= !last_el;
      done_q <= last_el;
    end else begin
      done_q <= 1'b0;
    end
  end

  assign busy = busy_q;
  assign done = done_q;

  // Addressing
  logic [OP_N-1:0][AW-1:0] op_idx;
  logic [AW-1:0]           s_idx;

  vmac_agen #(.AW(AW), .VLW(VLW)) u_agen (
    .base  (base_q),
    .vec   (vec_q),
    .elem  (elem_q),
    .vlen  (vl_q),
    .mode  (mode_q),
    .idx   (op_idx),
    .s_idx (s_idx)
  );

  // Register file
  logic [3:0][DW-1:0] rf_out;
  logic [DW-1:0]      prod_lo, prod_hi;

  vmac_rf #(.DW(DW), .NREG(NREG)) u_rf (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_idx ({rd_addr, op_idx[OP_C], op_idx[OP_B], op_idx[OP_A]}),
    .rd_val (rf_out),
    .lo_we  (step),
    .lo_idx (op_idx[OP_T]),
    .lo_val (prod_lo),
    .hi_we  (step),
    .hi_idx (s_idx),
    .hi_val (prod_hi),
    .ld_we  (ld_take),
    .ld_idx (ld_addr),
    .ld_val (ld_data)
  );

  assign rd_data = rf_out[3];

  vmac_alu #(.DW(DW)) u_alu (
    .a  (rf_out[0]),
    .b  (rf_out[1]),
    .c  (rf_out[2]),
    .lo (prod_lo),
    .hi (prod_hi)
  );

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R7
  fall_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R8
  empty_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    empty_op |=> (done && !busy));

  // R9
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(vl_q) && $stable(base_q) && $stable(mode_q)));

  // R2
  elem_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (elem_q == $past(elem_q) + VLW'(1)));

  // R13
  vl_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (vl_q <= VL_CAP) && (elem_q < vl_q));

endmodule

// File: tb/tb_vmac_seq.sv
`timescale 1ns/1ps
module tb_vmac_seq;

  localparam int CLK_NS = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [4:0]  vl = '0;
  logic        hi_mode = 1'b0;
  logic [5:0]  a_base = '0, b_base = '0, c_base = '0, t_base = '0;
  logic        a_vec = 1'b0, b_vec = 1'b0, c_vec = 1'b0, t_vec = 1'b0;
  logic        busy, done;
  logic        ld_we = 1'b0;
  logic [5:0]  ld_addr = '0;
  logic [63:0] ld_data = '0;
  logic [5:0]  rd_addr = '0;
  logic [63:0] rd_data;

  always #(CLK_NS/2) clk = ~clk;

  vmac_seq dut (
    .clk(clk), .rst_n(rst_n), .start(start), .vl(vl), .hi_mode(hi_mode),
    .a_base(a_base), .b_base(b_base), .c_base(c_base), .t_base(t_base),
    .a_vec(a_vec), .b_vec(b_vec), .c_vec(c_vec), .t_vec(t_vec),
    .busy(busy), .done(done), .ld_we(ld_we), .ld_addr(ld_addr),
    .ld_data(ld_data), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  int total = 0, bad = 0;
  bit finished = 1'b0;
  logic [63:0] mdl [64];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Restated product: 32-bit limbs, schoolbook
  function automatic logic [127:0] ref_mac(input logic [63:0] a, b, c);
    logic [127:0] a0, a1, b0, b1;
    a0 = 128'(a[31:0]); a1 = 128'(a[63:32]);
    b0 = 128'(b[31:0]); b1 = 128'(b[63:32]);
    return (a0*b0) + ((a1*b0) << 32) + ((a0*b1) << 32) + ((a1*b1) << 64) + 128'(c);
  endfunction

  task automatic model_run(input int n, input bit md,
                           input int a, input bit av, input int b, input bit bv,
                           input int c, input bit cv, input int t, input bit tv);
    for (int i = 0; i < n; i++) begin
      int ai, bi, ci, ti, si;
      logic [127:0] p;
      ai = (a + (av ? i : 0)) % 64;
      bi = (b + (bv ? i : 0)) % 64;
      ci = (c + (cv ? i : 0)) % 64;
      ti = (t + (tv ? i : 0)) % 64;
      si = md ? (ti + n) % 64 : ci;
      p = ref_mac(mdl[ai], mdl[bi], mdl[ci]);
      mdl[ti] = p[63:0];
      mdl[si] = p[127:64];
    end
  endtask

  task automatic load(input int idx, input logic [63:0] v);
    @(negedge clk);
    ld_we = 1'b1; ld_addr = 6'(idx); ld_data = v;
    @(negedge clk);
    ld_we = 1'b0;
    mdl[idx] = v;
  endtask

  task automatic check_rf(input string req);
    for (int r = 0; r < 64; r++) begin
      rd_addr = 6'(r);
      #1;
      chk(rd_data == mdl[r], req, $sformatf("reg[%0d]", r), 128'(rd_data), 128'(mdl[r]));
    end
  endtask

  task automatic set_op(input int n, input bit md,
                        input int a, input bit av, input int b, input bit bv,
                        input int c, input bit cv, input int t, input bit tv);
    vl = 5'(n); hi_mode = md;
    a_base = 6'(a); b_base = 6'(b); c_base = 6'(c); t_base = 6'(t);
    a_vec = av; b_vec = bv; c_vec = cv; t_vec = tv;
  endtask

  // Launch, count busy cycles, check the done pulse, update the model
  task automatic run_op(input string req, input int n, input int eff, input bit md,
                        input int a, input bit av, input int b, input bit bv,
                        input int c, input bit cv, input int t, input bit tv);
    int cnt;
    @(negedge clk);
    set_op(n, md, a, av, b, bv, c, cv, t, tv);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cnt = 0;
    while (busy && cnt < 64) begin
      cnt++;
      @(negedge clk);
    end
    chk(cnt == eff, "R7", {req, " busy cycles"}, 128'(cnt), 128'(eff));
    chk(done == 1'b1, "R7", {req, " done pulse"}, 128'(done), 128'(1));
    @(negedge clk);
    chk(done == 1'b0, "R7", {req, " done one cycle"}, 128'(done), 128'(0));
    model_run(eff, md, a, av, b, bv, c, cv, t, tv);
  endtask

  task automatic t_reset;
    for (int r = 0; r < 64; r++) mdl[r] = '0;
    chk(busy == 1'b0, "R1", "busy after reset", 128'(busy), 128'(0));
    chk(done == 1'b0, "R1", "done after reset", 128'(done), 128'(0));
    check_rf("R1");
  endtask

  task automatic t_carry_chain;
    for (int i = 0; i < 4; i++) load(i, 64'hF000_0000_0000_0001 + 64'(i) * 64'h1111_2222_3333_4444);
    load(10, 64'hFFFF_FFFF_0000_0007);
    load(11, 64'h0123_4567_89AB_CDEF);
    // R5: scalar C, mode 0 -> chain through reg 11
    run_op("R5", 4, 4, 1'b0, 0, 1'b1, 10, 1'b0, 11, 1'b0, 20, 1'b1);
    check_rf("R5");
  endtask

  task automatic t_vector_c;
    for (int i = 0; i < 4; i++) begin
      load(4 + i, 64'hDEAD_BEEF_0000_0000 ^ 64'(i * 977));
      load(30 + i, 64'h8000_0000_0000_0000 | 64'(i));
    end
    // R3 R4: all vector, high halves overwrite C elements
    run_op("R3", 4, 4, 1'b0, 0, 1'b1, 4, 1'b1, 30, 1'b1, 40, 1'b1);
    check_rf("R3");
  endtask

  task automatic t_separate;
    logic [63:0] c_before [4];
    for (int i = 0; i < 4; i++) c_before[i] = mdl[30 + i];
    // R6: mode 1, high halves land at 44..47
    run_op("R6", 4, 4, 1'b1, 0, 1'b1, 4, 1'b1, 30, 1'b1, 40, 1'b1);
    check_rf("R6");
    for (int i = 0; i < 4; i++) begin
      rd_addr = 6'(30 + i);
      #1;
      chk(rd_data == c_before[i], "R6", "C preserved", 128'(rd_data), 128'(c_before[i]));
    end
  endtask

  task automatic t_scalar_dest;
    // R4: scalar A and scalar low destination
    run_op("R4", 3, 3, 1'b1, 2, 1'b0, 4, 1'b1, 30, 1'b1, 55, 1'b0);
    check_rf("R4");
  endtask

  task automatic t_collide;
    load(50, 64'h0000_0000_0000_0003);
    load(51, 64'hFFFF_FFFF_FFFF_FFF1);
    load(52, 64'h1234_5678_9ABC_DEF0);
    // R10: T and C both reg 52, mode 0
    run_op("R10", 1, 1, 1'b0, 50, 1'b0, 51, 1'b0, 52, 1'b0, 52, 1'b0);
    check_rf("R10");
  endtask

  task automatic t_all_ones;
    load(60, '1); load(61, '1); load(62, '1);
    // R12: hi = all ones, lo = 0
    run_op("R12", 1, 1, 1'b1, 60, 1'b0, 61, 1'b0, 62, 1'b0, 63, 1'b0);
    rd_addr = 6'd63; #1;
    chk(rd_data == 64'h0, "R12", "low half", 128'(rd_data), 128'(0));
    rd_addr = 6'(63 + 1); #1;
    chk(rd_data == '1, "R12", "high half", 128'(rd_data), 128'(64'hFFFF_FFFF_FFFF_FFFF));
    check_rf("R12");
  endtask

  task automatic t_empty;
    // R8: VL=0
    run_op("R8", 0, 0, 1'b0, 0, 1'b1, 4, 1'b1, 30, 1'b1, 40, 1'b1);
    check_rf("R8");
  endtask

  task automatic t_clamp;
    // R13: VL=20 behaves as 16, destinations wrap past 63
    run_op("R13", 20, 16, 1'b1, 0, 1'b1, 10, 1'b0, 11, 1'b0, 56, 1'b1);
    check_rf("R13");
  endtask

  task automatic t_ignore;
    int cnt;
    logic [63:0] keep;
    keep = mdl[33];
    @(negedge clk);
    set_op(5, 1'b0, 0, 1'b1, 10, 1'b0, 11, 1'b0, 20, 1'b1);
    start = 1'b1;
    @(negedge clk);
    cnt = 1;
    // R9 R11: second start and a load while busy
    set_op(3, 1'b1, 4, 1'b0, 5, 1'b0, 6, 1'b1, 44, 1'b1);
    ld_we = 1'b1; ld_addr = 6'd33; ld_data = 64'h5555_AAAA_5555_AAAA;
    @(negedge clk);
    start = 1'b0; ld_we = 1'b0;
    while (busy && cnt < 64) begin
      cnt++;
      @(negedge clk);
    end
    chk(cnt == 5, "R9", "busy cycles of first op", 128'(cnt), 128'(5));
    chk(done == 1'b1, "R9", "done pulse", 128'(done), 128'(1));
    @(negedge clk);
    model_run(5, 1'b0, 0, 1'b1, 10, 1'b0, 11, 1'b0, 20, 1'b1);
    rd_addr = 6'd33; #1;
    chk(rd_data == keep, "R11", "load ignored while busy", 128'(rd_data), 128'(keep));
    check_rf("R9");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_carry_chain();
    t_vector_c();
    t_separate();
    t_scalar_dest();
    t_collide();
    t_all_ones();
    t_empty();
    t_clamp();
    t_ignore();
    // R2 covered by every register-file comparison above
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(CLK_NS * 200000);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule